// File: doc/BRIEF.md
# Burst Memory Port Sequencer

This block sits between user logic and a single-data-rate DRAM-style memory. It offers two independent user ports, one for writing and one for reading, over one shared data path. Each port loads a start address on a one-cycle enable pulse. From then on it walks forward one word per transfer, so a new load is needed only when a new region begins. A port asks for service by holding its ready line high. It keeps a burst going by also holding its burst line high, which lets FIFO flags drive the handshake directly.

Only one direction moves data at a time. An idle-state arbiter picks between a periodic refresh and the two ports. Before any word moves it opens a row, ends the burst at the last word of the row, and closes the row afterwards. If a port still has data pending, the same port goes through the cycle again. Write-done strobes mark the cycles in which the write data bus is consumed. Read-done strobes only mark requests, and each read word comes back a fixed number of cycles later with its own valid strobe. A small behavioural word store stands in for the memory array.

The controller has five states:
- `ST_IDLE`: arbitration. A pending refresh goes to `ST_REFRESH`; otherwise a port with ready high goes to `ST_OPEN`.
- `ST_REFRESH`: holds for `REF_LEN` cycles, then returns to `ST_IDLE`.
- `ST_OPEN`: holds for `OPEN_LAT-1` cycles, then goes to `ST_XFER`.
- `ST_XFER`: one word per cycle. It goes to `ST_CLOSE` when ready or burst is low, or when the word just moved sits at the last offset of its row.
- `ST_CLOSE`: lasts one cycle, then returns to `ST_IDLE`.

Top module: `burst_mem_seq`

## Requirements
- R1: A high `wr_aen`/`rd_aen` in a cycle loads that port's 26-bit address bus as the next word address. The address bus is ignored in all other cycles.
- R2: After every word a port transfers, its address advances by one, wrapping modulo 2^26.
- R3: From idle, with no refresh pending, the first done strobe comes exactly 4 cycles after the cycle in which the port's ready is first seen high.
- R4: In every cycle with `wr_done` high, the 32-bit `wr_data` is stored at the port's current address. The word store holds 2^MEM_AW words, indexed by the low MEM_AW address bits.
- R5: While ready and burst both stay high, done strobes come on consecutive cycles. A done cycle in which burst (or ready) is low carries the final word, and no further done follows.
- R6: A row is 2^ROW_BITS words (default 512), selected by the upper address bits. After a word at the last offset of a row, the burst closes. If the port still requests, its next done comes exactly 6 cycles after that word.
- R7: Every `rd_done` cycle is followed, exactly 5 cycles later, by one `rd_dval` cycle carrying the stored word at the requested address. `rd_dval` is never high otherwise.
- R8: `rd_done` and `wr_done` are never high in the same cycle.
- R9: When both ports request in idle, the port not served last wins; after reset the read port wins. The losing port's first done comes 6 cycles after the winner's last word.
- R10: A refresh falls due every REF_PERIOD cycles counted from reset and occupies the path for 8 cycles before the next access. A request whose ready rises in the cycle the refresh falls due sees its first done 13 cycles later.
- R11: During and right after reset, `wr_done`, `rd_done` and `rd_dval` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_aen | input | 1 | Write address load strobe |
| wr_addr | input | 26 | Write start address |
| wr_ready | input | 1 | Write data is available |
| wr_burst | input | 1 | More than one write word remains |
| wr_data | input | 32 | Write word, consumed in `wr_done` cycles |
| wr_done | output | 1 | A write word is taken this cycle |
| rd_aen | input | 1 | Read address load strobe |
| rd_addr | input | 26 | Read start address |
| rd_ready | input | 1 | Space exists to receive read words |
| rd_burst | input | 1 | More than one read word is wanted |
| rd_done | output | 1 | A read word is requested this cycle |
| rd_dval | output | 1 | `rd_data` holds a returned word |
| rd_data | output | 32 | Returned read word |

## Verification
Each result has a fixed due cycle, counted from the cycle in which the stimulus is applied:
- First done: 4 cycles after ready rises.
- Next burst word: 1 cycle after the previous word.
- Next row, or the losing port of an arbitration: 6 cycles after the previous word.
- First done behind a refresh: 13 cycles after ready rises.
- Read data valid: 5 cycles after its request.

The bench stamps every done and valid cycle with a free-running cycle count and compares the differences with these figures. Before each access it waits for a phase of the refresh period where no refresh can intervene, except in the refresh tests, which align the request to the cycle the refresh falls due. Write words go into a bench shadow store, so each read-back word is compared with the word its address last received.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFRESH,
        ST_OPEN,
        ST_XFER,
        ST_CLOSE
    } seq_state_t;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } seq_dir_t;

endpackage

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
    parameter int PERIOD = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            due   <= wrap | (due & ~ack);
        end
    end
endmodule

// File: rtl/seq_addr_ptr.sv
module seq_addr_ptr #(
    parameter int AW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (load)  ptr <= load_val;
        else if (step)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/seq_word_store.sv
module seq_word_store #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/seq_read_pipe.sv
module seq_read_pipe #(
    parameter int DW    = 32,
    parameter int DEPTH = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic [DW-1:0] out_data
);
    logic          vld_q [DEPTH];
    logic [DW-1:0] dat_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    dat_q[0] <= '0;
                end else begin
                    vld_q[0] <= in_vld;
                    dat_q[0] <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    dat_q[g] <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    dat_q[g] <= dat_q[g-1];
                end
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_data = dat_q[DEPTH-1];
endmodule

// File: rtl/burst_mem_seq.sv
module burst_mem_seq
    import mem_seq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 26,
    parameter int ROW_BITS   = 9,
    parameter int MEM_AW     = 10,
    parameter int OPEN_LAT   = 4,
    parameter int RD_LAT     = 5,
    parameter int REF_PERIOD = 1040,
    parameter int REF_LEN    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_aen,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_ready,
    input  logic              wr_burst,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_done,
    input  logic              rd_aen,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rd_burst,
    output logic              rd_done,
    output logic              rd_dval,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HOLD_MAX = (OPEN_LAT > REF_LEN) ? OPEN_LAT : REF_LEN;
    localparam int CNT_W    = $clog2(HOLD_MAX + 1);

    seq_state_t          state_q, state_d;
    seq_dir_t            dir_q, dir_d;
    seq_dir_t            last_q, last_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                ref_due, ref_ack;
    logic [ADDR_W-1:0]   wr_ptr, rd_ptr;
    logic [DATA_W-1:0]   store_rdata;
    logic                cur_ready, cur_burst, row_last;

    seq_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
    );

    seq_addr_ptr #(.AW(ADDR_W)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .load(wr_aen), .load_val(wr_addr),
        .step(wr_done), .ptr(wr_ptr)
    );

    seq_addr_ptr #(.AW(ADDR_W)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .load(rd_aen), .load_val(rd_addr),
        .step(rd_done), .ptr(rd_ptr)
    );

    seq_word_store #(.DW(DATA_W), .AW(MEM_AW)) u_store (
        .clk(clk), .we(wr_done), .waddr(wr_ptr[MEM_AW-1:0]), .wdata(wr_data),
        .raddr(rd_ptr[MEM_AW-1:0]), .rdata(store_rdata)
    );

    seq_read_pipe #(.DW(DATA_W), .DEPTH(RD_LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_vld(rd_done), .in_data(store_rdata),
        .out_vld(rd_dval), .out_data(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_RD;
            last_q  <= DIR_WR;   // read wins the first tie after reset
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            last_q  <= last_d;
            cnt_q   <= cnt_d;
        end
    end

    // selected port view
    always_comb begin
        cur_ready = (dir_q == DIR_WR) ? wr_ready : rd_ready;
        cur_burst = (dir_q == DIR_WR) ? wr_burst : rd_burst;
        row_last  = (dir_q == DIR_WR) ? (&wr_ptr[ROW_BITS-1:0])
                                      : (&rd_ptr[ROW_BITS-1:0]);
    end

    // next state
    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        last_d  = last_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_due) begin
                    state_d = ST_REFRESH;
                    cnt_d   = '0;
                end else if (rd_ready || wr_ready) begin
                    state_d = ST_OPEN;
                    cnt_d   = '0;
                    if (rd_ready && wr_ready)
                        dir_d = (last_q == DIR_WR) ? DIR_RD : DIR_WR;
                    else
                        dir_d = wr_ready ? DIR_WR : DIR_RD;
                    last_d = dir_d;
                end
            end
            ST_REFRESH: begin
                if (cnt_q == CNT_W'(REF_LEN - 1)) state_d = ST_IDLE;
                else                              cnt_d   = cnt_q + 1'b1;
            end
            ST_OPEN: begin
                if (cnt_q == CNT_W'(OPEN_LAT - 2)) state_d = ST_XFER;
                else                               cnt_d   = cnt_q + 1'b1;
            end
            ST_XFER: begin
                if (!(cur_ready && cur_burst && !row_last)) state_d = ST_CLOSE;
            end
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_done = (state_q == ST_XFER) && (dir_q == DIR_WR);
        rd_done = (state_q == ST_XFER) && (dir_q == DIR_RD);
        ref_ack = (state_q == ST_IDLE) && ref_due;
    end
endmodule

// File: rtl/burst_mem_seq_chk.sv
module burst_mem_seq_chk #(
    parameter int ADDR_W   = 26,
    parameter int ROW_BITS = 9,
    parameter int RD_LAT   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_aen,
    input logic              rd_aen,
    input logic              wr_burst,
    input logic              rd_burst,
    input logic              wr_done,
    input logic              rd_done,
    input logic              rd_dval,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] rd_ptr
);
    logic [RD_LAT-1:0] req_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_hist <= '0;
        else        req_hist <= {req_hist[RD_LAT-2:0], rd_done};
    end

    assert_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && wr_done));

    assert_dval_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dval == req_hist[RD_LAT-1]);

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !wr_aen) |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));

    assert_rd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_aen) |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

    assert_wr_row_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && (&wr_ptr[ROW_BITS-1:0])) |=> !wr_done);

    assert_rd_row_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && (&rd_ptr[ROW_BITS-1:0])) |=> !rd_done);

    assert_wr_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !wr_burst) |=> !wr_done);

    assert_rd_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_burst) |=> !rd_done);
endmodule

bind burst_mem_seq burst_mem_seq_chk #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .RD_LAT(RD_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_aen(wr_aen), .rd_aen(rd_aen),
    .wr_burst(wr_burst), .rd_burst(rd_burst), .wr_done(wr_done),
    .rd_done(rd_done), .rd_dval(rd_dval), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/tb_burst_mem_seq.sv
module tb_burst_mem_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ROWB = 4;
    localparam int MAW  = 6;
    localparam int RP   = 400;
    localparam int RL   = 8;
    localparam int OL   = 4;
    localparam int RDL  = 5;
    localparam int GAP  = OL + 2;
    localparam int RLAT = OL + RL + 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_aen, wr_ready, wr_burst, wr_done;
    logic [25:0] wr_addr;
    logic [31:0] wr_data;
    logic        rd_aen, rd_ready, rd_burst, rd_done, rd_dval;
    logic [25:0] rd_addr;
    logic [31:0] rd_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_mem_seq #(
        .ROW_BITS(ROWB), .MEM_AW(MAW), .OPEN_LAT(OL), .RD_LAT(RDL),
        .REF_PERIOD(RP), .REF_LEN(RL)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_aen(wr_aen), .wr_addr(wr_addr), .wr_ready(wr_ready),
        .wr_burst(wr_burst), .wr_data(wr_data), .wr_done(wr_done),
        .rd_aen(rd_aen), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_burst(rd_burst), .rd_done(rd_done), .rd_dval(rd_dval),
        .rd_data(rd_data)
    );

    int cyc;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int          n_chk = 0;
    int          n_bad = 0;
    int          excl_bad = 0;
    bit          finished = 0;
    bit          last_wr = 1'b1;
    logic [31:0] shadow    [64];
    bit          shadow_ok [64];
    int          rq_stamp [$];
    logic [31:0] rq_data  [$];
    bit          rq_chk   [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [25:0] a, input int seed);
        return (32'(seed) * 32'h9E3779B1) ^ {6'd0, a};
    endfunction

    // wait for a refresh-free window of 'need' cycles, ending at posedge+1
    task automatic quiet(input int need);
        do begin
            @(posedge clk); #1;
        end while (((cyc % RP) < 16) || ((cyc % RP) + need > RP - 4));
    endtask

    // R1: address bus is scrambled right after the load pulse
    task automatic do_write(input logic [25:0] a, input int n, input int seed,
                            input int exp_lat, input bit strict,
                            output int first_c, output int last_c);
        logic [25:0] cur, prev_a;
        int got, c0, prev_c;
        bit consumed;
        got = 0; consumed = 0; prev_c = 0; prev_a = '0;
        first_c = -1;
        wr_aen = 1'b1; wr_addr = a;
        @(posedge clk); #1;
        wr_aen = 1'b0; wr_addr = ~a; wr_ready = 1'b1; wr_burst = (n > 1);
        cur = a; wr_data = pat(a, seed); c0 = cyc;
        while (got < n) begin
            @(posedge clk); #1;
            if (consumed) begin
                cur = cur + 1'b1; wr_data = pat(cur, seed); consumed = 0;
            end
            if (wr_done) begin
                shadow[cur[5:0]] = wr_data; shadow_ok[cur[5:0]] = 1'b1;
                if (got == 0) begin
                    first_c = cyc;
                    if (exp_lat >= 0)
                        chk(cyc - c0 == exp_lat, "R3/R10 write first-done latency", cyc - c0, exp_lat);
                end else if (strict) begin
                    if (&prev_a[ROWB-1:0])
                        chk(cyc - prev_c == GAP, "R6 write row reopen gap", cyc - prev_c, GAP);
                    else
                        chk(cyc - prev_c == 1, "R5 write burst continuity", cyc - prev_c, 1);
                end
                prev_c = cyc; prev_a = cur; got++; consumed = 1;
                if (got == n) begin wr_burst = 1'b0; wr_ready = 1'b0; end
            end
        end
        last_c = prev_c;
    endtask

    task automatic do_read(input logic [25:0] a, input int n,
                           input int exp_lat, input bit strict,
                           output int first_c, output int last_c);
        logic [25:0] cur, prev_a;
        int got, c0, prev_c;
        got = 0; prev_c = 0; prev_a = '0;
        first_c = -1;
        rd_aen = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        rd_aen = 1'b0; rd_addr = ~a; rd_ready = 1'b1; rd_burst = (n > 1);
        cur = a; c0 = cyc;
        while (got < n) begin
            @(posedge clk); #1;
            if (rd_done) begin
                rq_stamp.push_back(cyc);
                rq_data.push_back(shadow[cur[5:0]]);
                rq_chk.push_back(shadow_ok[cur[5:0]]);
                if (got == 0) begin
                    first_c = cyc;
                    if (exp_lat >= 0)
                        chk(cyc - c0 == exp_lat, "R3/R10 read first-done latency", cyc - c0, exp_lat);
                end else if (strict) begin
                    if (&prev_a[ROWB-1:0])
                        chk(cyc - prev_c == GAP, "R6 read row reopen gap", cyc - prev_c, GAP);
                    else
                        chk(cyc - prev_c == 1, "R5 read burst continuity", cyc - prev_c, 1);
                end
                prev_c = cyc; prev_a = cur; cur = cur + 1'b1; got++;
                if (got == n) begin rd_burst = 1'b0; rd_ready = 1'b0; end
            end
        end
        last_c = prev_c;
    endtask

    // R5: no stray done after the final word
    task automatic no_more(input int k);
        int extra;
        extra = 0;
        repeat (k) begin
            @(posedge clk); #1;
            if (wr_done || rd_done) extra++;
        end
        chk(extra == 0, "R5 no done after final word", extra, 0);
    endtask

    // monitor: R7 return timing and data, R8 exclusivity, last served port
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (rd_done && wr_done) excl_bad++;
                if (wr_done)      last_wr = 1'b1;
                else if (rd_done) last_wr = 1'b0;
                if (rd_dval) begin
                    if (rq_stamp.size() == 0) begin
                        chk(1'b0, "R7 valid without request", cyc, -1);
                    end else begin
                        int st;
                        logic [31:0] d;
                        bit c;
                        st = rq_stamp.pop_front();
                        d  = rq_data.pop_front();
                        c  = rq_chk.pop_front();
                        chk(cyc == st + RDL, "R7 valid delay", cyc - st, RDL);
                        if (c) chk(rd_data == d, "R7/R4 read data", rd_data, d);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    logic [25:0] w_addr [6];
    int          w_len  [6];
    int          r_len  [6];

    initial begin
        int wf, wl, rf, rl;
        bit prev_wr;
        for (int i = 0; i < 64; i++) begin shadow[i] = '0; shadow_ok[i] = 1'b0; end
        w_addr[0] = 26'h0000000; w_len[0] = 1;  r_len[0] = 1;
        w_addr[1] = 26'h0000003; w_len[1] = 2;  r_len[1] = 2;
        w_addr[2] = 26'h000000E; w_len[2] = 3;  r_len[2] = 3;
        w_addr[3] = 26'h0000028; w_len[3] = 5;  r_len[3] = 4;
        w_addr[4] = 26'h0000030; w_len[4] = 16; r_len[4] = 16;
        w_addr[5] = 26'h3FFFFF8; w_len[5] = 20; r_len[5] = 20;
        rst_n = 1'b0;
        wr_aen = 0; wr_addr = '0; wr_ready = 0; wr_burst = 0; wr_data = '0;
        rd_aen = 0; rd_addr = '0; rd_ready = 0; rd_burst = 0;
        repeat (3) @(negedge clk);
        chk(!wr_done && !rd_done && !rd_dval, "R11 outputs low in reset",
            {wr_done, rd_done, rd_dval}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!wr_done && !rd_done && !rd_dval, "R11 outputs low after reset",
            {wr_done, rd_done, rd_dval}, 0);

        // R9: tie after reset goes to the read port
        quiet(60);
        fork
            do_write(26'h0000100, 2, 1, -1, 1'b0, wf, wl);
            do_read (26'h0000235, 2, OL, 1'b1, rf, rl);
        join
        chk(rf < wf, "R9 read wins first tie", rf, wf);
        chk(wf == rl + GAP, "R9 loser starts after winner", wf - rl, GAP);
        no_more(8);

        // write sweep: lengths, row crossings, address wrap
        for (int i = 0; i < 6; i++) begin
            quiet(80);
            do_write(w_addr[i], w_len[i], 10 + i, OL, 1'b1, wf, wl);
            no_more(8);
        end

        // read-back sweep
        for (int i = 0; i < 6; i++) begin
            quiet(80);
            do_read(w_addr[i], r_len[i], OL, 1'b1, rf, rl);
            no_more(10);
        end

        // R9: round robin, twice
        for (int k = 0; k < 2; k++) begin
            quiet(80);
            prev_wr = last_wr;
            fork
                do_write(26'h0000010 + 26'(4 * k), 4, 30 + k, -1, 1'b1, wf, wl);
                do_read (26'h0000030 + 26'(4 * k), 4, -1, 1'b1, rf, rl);
            join
            if (prev_wr) begin
                chk(rf < wf, "R9 read served first", rf, wf);
                chk(wf == rl + GAP, "R9 write follows read", wf - rl, GAP);
            end else begin
                chk(wf < rf, "R9 write served first", wf, rf);
                chk(rf == wl + GAP, "R9 read follows write", rf - wl, GAP);
            end
            no_more(10);
        end

        // R10: ready rises in the cycle a refresh falls due
        quiet(20);
        while (((cyc + 1) % RP) != 0) begin @(posedge clk); #1; end
        do_write(26'h0000008, 2, 40, RLAT, 1'b1, wf, wl);
        no_more(8);
        quiet(20);
        while (((cyc + 1) % RP) != 0) begin @(posedge clk); #1; end
        do_read(26'h0000008, 2, RLAT, 1'b1, rf, rl);
        no_more(12);

        chk(excl_bad == 0, "R8 dones never together", excl_bad, 0);
        chk(rq_stamp.size() == 0, "R7 every request returned", rq_stamp.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule